// File: doc/BRIEF.md
# Composite-Field AES Forward Substitution Box

This block performs the forward AES byte substitution with arithmetic logic instead of a 256-entry lookup table. The incoming byte is first changed into a tower representation built from three nested degree-2 extensions over GF(2). In that representation its multiplicative inverse is formed from GF(2^4) and GF(2^2) products, squares and one small inversion. A single linear layer then returns the inverse to the standard polynomial basis and applies the affine step of the cipher.

All basis-change matrices are derived during elaboration from the field constants. The derivation searches for a root of the AES reduction polynomial inside the tower field, so no matrix is entered by hand. A parameter chooses either a purely combinational path or two register stages, one after the basis change and one after the inversion. A valid flag travels alongside the data with the same latency.

Top module: `aes_tower_sbox`

## Requirements
- R1: For every input byte, out_byte equals the AES forward S-box value: the inverse modulo x^8+x^4+x^3+x+1, with zero taken as its own inverse, followed by the affine map b ^ rotl(b,1) ^ rotl(b,2) ^ rotl(b,3) ^ rotl(b,4) ^ 0x63.
- R2: Input 0x00 yields 0x63, because zero passes through the inversion unchanged.
- R3: With PIPE_STAGES = 0 the result appears in the same cycle as the input. With PIPE_STAGES = 2 it appears two rising edges after the edge that samples the input.
- R4: out_valid equals in_valid delayed by the same latency as the data, so bubbles in the input stream reappear unchanged at the output.
- R5: When the synchronous reset rst is high at a rising edge, both valid stages clear. out_valid is low in the cycle after that edge, even if in_valid was high.
- R6: When new bytes arrive on consecutive cycles, each result is delivered in order and none is lost or repeated.
- R7: Inside the tower field, the inversion stage returns y with a·y = 1 for every nonzero a, and returns 0 for a = 0.
- R8: Boundary bytes map as 0x01 -> 0x7C, 0xFF -> 0x16 and 0x80 -> 0xCD.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the pipeline registers |
| rst | input | 1 | Synchronous active-high reset of the valid stages |
| in_valid | input | 1 | Marks in_byte as carrying a byte to substitute |
| in_byte | input | 8 | Byte in the standard AES basis |
| out_valid | output | 1 | Marks out_byte as a delivered result |
| out_byte | output | 8 | Substituted byte in the standard AES basis |

## Verification
The bench aims at 0x00, where a design that inverts zero incorrectly or drops the affine constant gives a value other than 0x63. It also checks the bytes whose images land on the basis vectors, where an error in a single column of a derived matrix corrupts only a few outputs. A swapped nibble order or a wrong subfield constant fails most of the 256 inputs, which are compared against a reference built by brute-force inversion. The streaming test sends bytes back to back with periodic gaps, so any latency or valid misalignment shows up as shifted data or a displaced bubble. A reset applied while valid bytes are in flight must clear out_valid on the following cycle.

// File: rtl/aes_tower_pkg.sv
package aes_tower_pkg;

  typedef logic [7:0] byte_t;
  typedef logic [7:0][7:0] mat8_t;

  localparam logic [1:0] PHI    = 2'b10;
  localparam logic [3:0] LAMBDA = 4'b1100;
  localparam byte_t AFF_CONST   = 8'h63;

  // GF(2^2), x^2 = x + 1
  function automatic logic [1:0] gf4_mul(logic [1:0] a, logic [1:0] b);
    logic hh;
    hh = a[1] & b[1];
    return {hh ^ (a[1] & b[0]) ^ (a[0] & b[1]), hh ^ (a[0] & b[0])};
  endfunction

  function automatic logic [1:0] gf4_sq(logic [1:0] a);
    return {a[1], a[1] ^ a[0]};
  endfunction

  function automatic logic [1:0] gf4_mul_phi(logic [1:0] a);
    return gf4_mul(a, PHI);
  endfunction

  // GF(2^4), y^2 = y + phi
  function automatic logic [3:0] gf16_mul(logic [3:0] a, logic [3:0] b);
    logic [1:0] hh;
    hh = gf4_mul(a[3:2], b[3:2]);
    return {hh ^ gf4_mul(a[3:2], b[1:0]) ^ gf4_mul(a[1:0], b[3:2]),
            gf4_mul_phi(hh) ^ gf4_mul(a[1:0], b[1:0])};
  endfunction

  function automatic logic [3:0] gf16_sq(logic [3:0] a);
    logic [1:0] h2;
    h2 = gf4_sq(a[3:2]);
    return {h2, gf4_mul_phi(h2) ^ gf4_sq(a[1:0])};
  endfunction

  function automatic logic [3:0] gf16_inv(logic [3:0] a);
    logic [1:0] nrm, ninv;
    nrm  = gf4_mul_phi(gf4_sq(a[3:2])) ^ gf4_mul(a[3:2], a[1:0]) ^ gf4_sq(a[1:0]);
    ninv = gf4_sq(nrm);
    return {gf4_mul(a[3:2], ninv), gf4_mul(a[3:2] ^ a[1:0], ninv)};
  endfunction

  // GF(2^8) tower, z^2 = z + lambda
  function automatic byte_t gf256t_mul(byte_t a, byte_t b);
    logic [3:0] hh;
    hh = gf16_mul(a[7:4], b[7:4]);
    return {hh ^ gf16_mul(a[7:4], b[3:0]) ^ gf16_mul(a[3:0], b[7:4]),
            gf16_mul(hh, LAMBDA) ^ gf16_mul(a[3:0], b[3:0])};
  endfunction

  function automatic byte_t gf256t_inv(byte_t a);
    logic [3:0] nrm, ninv;
    nrm  = gf16_mul(gf16_sq(a[7:4]), LAMBDA) ^ gf16_mul(a[7:4], a[3:0]) ^ gf16_sq(a[3:0]);
    ninv = gf16_inv(nrm);
    return {gf16_mul(a[7:4], ninv), gf16_mul(a[7:4] ^ a[3:0], ninv)};
  endfunction

  function automatic byte_t mat_apply(mat8_t m, byte_t v);
    byte_t r;
    r = '0;
    for (int i = 0; i < 8; i++) if (v[i]) r = r ^ m[i];
    return r;
  endfunction

  function automatic byte_t rotl8(byte_t b, int k);
    return byte_t'((b << k) | (b >> (8 - k)));
  endfunction

  function automatic byte_t affine_lin(byte_t b);
    return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4);
  endfunction

  // Column i holds beta^i, beta a tower-field root of the AES polynomial.
  function automatic mat8_t build_iso();
    mat8_t m;
    byte_t pw [9];
    byte_t chk;
    logic found;
    m = '0;
    found = 1'b0;
    for (int c = 2; c < 256; c++) begin
      if (!found) begin
        pw[0] = 8'h01;
        for (int k = 1; k < 9; k++) pw[k] = gf256t_mul(pw[k-1], byte_t'(c));
        chk = pw[8] ^ pw[4] ^ pw[3] ^ pw[1] ^ pw[0];
        if (chk == 8'h00) begin
          found = 1'b1;
          for (int k = 0; k < 8; k++) m[k] = pw[k];
        end
      end
    end
    return m;
  endfunction

  localparam mat8_t ISO_M = build_iso();

  // Column j: affine-linear part applied to the standard byte whose image is e_j.
  function automatic mat8_t build_out();
    mat8_t m;
    m = '0;
    for (int j = 0; j < 8; j++)
      for (int s = 0; s < 256; s++)
        if (mat_apply(ISO_M, byte_t'(s)) == byte_t'(1 << j)) m[j] = affine_lin(byte_t'(s));
    return m;
  endfunction

  localparam mat8_t OUT_M = build_out();

endpackage

// File: rtl/tower_map.sv
module tower_map
  import aes_tower_pkg::*;
(
  input  byte_t std_byte,
  output byte_t twr_byte
);
  assign twr_byte = mat_apply(ISO_M, std_byte);

  // R1: a basis change is injective, so zero and only zero maps to zero
  always_comb begin
    if (!$isunknown(std_byte))
      p_map_zero_r1: assert ((std_byte == 8'h00) == (twr_byte == 8'h00));
  end
endmodule

// File: rtl/tower_inverse.sv
module tower_inverse
  import aes_tower_pkg::*;
(
  input  byte_t a,
  output byte_t y
);
  assign y = gf256t_inv(a);

  always_comb begin
    if (!$isunknown(a)) begin
      if (a == 8'h00) p_inv_zero_r7: assert (y == 8'h00);
      else            p_inv_prod_r7: assert (gf256t_mul(a, y) == 8'h01);
    end
  end
endmodule

// File: rtl/tower_unmap_affine.sv
module tower_unmap_affine
  import aes_tower_pkg::*;
(
  input  byte_t twr_byte,
  output byte_t sub_byte
);
  assign sub_byte = mat_apply(OUT_M, twr_byte) ^ AFF_CONST;

  always_comb begin
    if (twr_byte == 8'h00) p_zero_const_r2: assert (sub_byte == 8'h63);
  end
endmodule

// File: rtl/aes_tower_sbox.sv
module aes_tower_sbox
  import aes_tower_pkg::*;
#(
  parameter int PIPE_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       out_valid,
  output logic [7:0] out_byte
);
  localparam bit REGISTERED = (PIPE_STAGES != 0);

  byte_t mapped, map_q, inv_out, inv_q;
  logic  v1, v2;

  tower_map          u_map (.std_byte(in_byte), .twr_byte(mapped));
  tower_inverse      u_inv (.a(map_q), .y(inv_out));
  tower_unmap_affine u_out (.twr_byte(inv_q), .sub_byte(out_byte));

  generate
    if (!REGISTERED) begin : g_comb
      assign map_q = mapped;
      assign v1    = in_valid;
      assign inv_q = inv_out;
      assign v2    = v1;
    end else begin : g_pipe
      always_ff @(posedge clk) begin
        if (rst) begin
          v1 <= 1'b0;
          v2 <= 1'b0;
        end else begin
          v1 <= in_valid;
          v2 <= v1;
        end
        if (in_valid) map_q <= mapped;
        if (v1)       inv_q <= inv_out;
      end

      p_valid_lat_r4: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ##1 out_valid);
      p_bubble_lat_r4: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ##1 !out_valid);
      p_rst_clear_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !out_valid);
      p_hold_data_r6: assert property (@(posedge clk) disable iff (rst)
        !v1 |=> $stable(inv_q));
    end
  endgenerate

  assign out_valid = v2;
endmodule

// File: tb/test_aes_tower_sbox.sv
`timescale 1ns/1ps
module test_aes_tower_sbox;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic p_valid, c_valid;
  logic [7:0] p_byte, c_byte;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  aes_tower_sbox #(.PIPE_STAGES(2)) i_aes_tower_sbox (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .out_valid(p_valid), .out_byte(p_byte));

  aes_tower_sbox #(.PIPE_STAGES(0)) i_aes_tower_sbox_comb (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .out_valid(c_valid), .out_byte(c_byte));

  // input, expected (known S-box pairs)
  localparam logic [15:0] VEC [8] = '{16'h0063, 16'h017C, 16'hFF16, 16'h80CD,
                                      16'h53ED, 16'h10CA, 16'h7FD2, 16'hC9DD};

  // reference: shift-and-add product reduced by 0x11B
  function automatic int rmul(int a, int b);
    int r = 0;
    int x = a;
    for (int k = 0; k < 8; k++) begin
      if ((b >> k) & 1) r ^= x;
      x = x << 1;
      if (x & 256) x ^= 'h11B;
    end
    return r;
  endfunction

  function automatic int rsbox(int v);
    int inv = 0;
    int s;
    for (int c = 1; c < 256; c++) if (rmul(v, c) == 1) inv = c;
    s = inv;
    for (int k = 1; k < 5; k++) s ^= ((inv << k) | (inv >> (8 - k))) & 'hFF;
    return s ^ 'h63;
  endfunction

  int ref_tab [256];

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #500000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  int sent_v [400];
  int sent_b [400];

  initial begin
    int nxt;
    for (int v = 0; v < 256; v++) ref_tab[v] = rsbox(v);

    // R5: reset holds valid low even with in_valid high
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    check("R5 valid in reset", int'(p_valid), 0);
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check("R5 valid after reset", int'(p_valid), 0);

    // streaming with periodic bubbles: R1 R3 R4 R6 R7
    nxt = 0;
    for (int t = 0; t < 340; t++) begin
      @(negedge clk);
      if (t >= 2) begin
        check("R4 valid latency", int'(p_valid), sent_v[t-2]);
        if (sent_v[t-2] != 0) check("R1 R6 pipelined data", int'(p_byte), ref_tab[sent_b[t-2]]);
      end
      sent_v[t] = ((t % 5) != 4 && nxt < 256) ? 1 : 0;
      sent_b[t] = nxt & 255;
      in_valid = sent_v[t][0];
      in_byte = 8'(nxt);
      #1;
      check("R3 comb valid", int'(c_valid), sent_v[t]);
      if (sent_v[t] != 0) begin
        check("R1 R7 comb data", int'(c_byte), ref_tab[nxt]);
        nxt++;
      end
    end
    in_valid = 1'b0;

    // table of directed vectors: R2 R8
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_byte = VEC[k][15:8];
      #1;
      check(k == 0 ? "R2 comb zero" : "R8 comb boundary", int'(c_byte), int'(VEC[k][7:0]));
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      check("R3 pipe valid after two edges", int'(p_valid), 1);
      check(k == 0 ? "R2 pipe zero" : "R8 pipe boundary", int'(p_byte), int'(VEC[k][7:0]));
    end

    // R5: reset while valid bytes are in flight
    @(negedge clk);
    in_valid = 1'b1;
    in_byte = 8'h01;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R5 flush in flight", int'(p_valid), 0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    check("R5 no stale valid", int'(p_valid), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule